// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block keeps two per-CPU pending masks for a small multiprocessor (up to four CPUs): one for inter-processor interrupts and one for interval-timer interrupts. Each pending bit drives a level interrupt line to its CPU. The IPI bits drive the level-3 lines and the timer bits drive the level-2 lines. Software reaches the block through a simple 64-bit register port that carries the accessing CPU's number as a sideband. An external periodic source pulses `timer_tick` to raise the timer interrupt on every configured CPU.

A packed control register can request IPIs, drop IPIs and drop timer interrupts for several CPUs in one write. Requests only set bits and clears only drop them. Three dedicated registers give direct access to the two masks: read the IPI mask and clear bits in it, read the timer mask and clear bits in it, and request IPIs. Misuse is recorded in sticky flags, and only reset clears them. Misuse means requesting an IPI that is already pending, clearing one that is not pending, writing a control word with no recognised field, or writing an empty mask to a dedicated register.

Top module: `ipt_unit`

## Requirements
- R1: After reset, all pending bits, all interrupt lines, all four sticky flags and `rsp_valid` are 0.
- R2: A write to register 0 (control) raises the IPI line of every configured CPU whose bit is set in data bits 15:12 (bit 12 = CPU 0). The line goes high in the cycle after the write and stays high until that CPU's IPI is cleared.
- R3: In a control write, data bits 11:8 clear the IPI pending bits and data bits 7:4 clear the timer pending bits of the CPUs in those masks. All fields of one write take effect together. If the same CPU is both requested and cleared in one write, the request wins.
- R4: A one-cycle pulse on `timer_tick` sets the timer pending bit of every configured CPU, and that CPU's timer line is high from the next cycle. If a timer clear for a CPU falls in the same cycle as a tick, the tick wins.
- R5: Only CPUs numbered below `NUM_CPUS` are affected. Mask bits for higher CPUs are ignored, and the lines of those CPUs stay at 0.
- R6: A read sets `rsp_valid` in the next cycle. A read of register 0 returns the accessing CPU's number in bits 1:0, the timer mask in bits 7:4 and the IPI mask in bits 11:8, with all other bits 0. The values reported are those held before the cycle of the read.
- R7: The dedicated registers take their CPU mask from data bits 3:0 and report a mask in read bits 3:0. Register 1 reads the IPI mask, and writing it clears the written bits. Register 2 reads the timer mask, and writing it clears the written bits. Writing register 3 requests IPIs for the written mask, and reading it returns 0.
- R8: An IPI request for a configured CPU that already has an IPI pending sets `warn_dup_req`. An IPI clear for a configured CPU that has none pending sets `warn_spur_clr`. Neither case changes that CPU's pending bit beyond the stated semantics.
- R9: A control write with bits 15:4 all zero and bit 28 clear sets `err_unsupported`. A control write with bit 28 set and no other field is accepted and changes nothing.
- R10: A write to register 1, 2 or 3 with data bits 3:0 all zero sets `err_zero_mask` and leaves the IPI mask unchanged.
- R11: Once set, each of the four flags stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register index (0 control, 1 IPI status, 2 timer status, 3 IPI request) |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | CPU_W | Number of the accessing CPU |
| timer_tick | input | 1 | Interval timer pulse |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | DATA_W | Read data |
| ipi_irq | output | MAX_CPUS | Level-3 IPI line per CPU |
| tmr_irq | output | MAX_CPUS | Level-2 timer line per CPU |
| warn_dup_req | output | 1 | Sticky: IPI requested while already pending |
| warn_spur_clr | output | 1 | Sticky: IPI cleared while not pending |
| err_unsupported | output | 1 | Sticky: control write with no recognised field |
| err_zero_mask | output | 1 | Sticky: dedicated write with an empty mask |

## Verification
Two updates can meet on the timer mask in one cycle: the tick that sets it and a write that clears it, through either the control register or the timer status register. On the IPI side, a single control write can both request and clear the same CPU. The bench provokes both collisions directly: it pulses the tick in the same cycle as a timer-clear write, and it writes one word with overlapping request and clear fields. The random phase then lets ticks land on random writes. Every outcome is judged against a bench model in which set beats clear, checked at the interrupt lines and through register read-back.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

   typedef enum logic [1:0] {
      REG_CTRL     = 2'd0,
      REG_IPI_STAT = 2'd1,
      REG_TMR_STAT = 2'd2,
      REG_IPI_REQ  = 2'd3
   } ipt_reg_e;

   localparam int unsigned CTRL_IPI_REQ_LSB = 12;
   localparam int unsigned CTRL_IPI_CLR_LSB = 8;
   localparam int unsigned CTRL_TMR_CLR_LSB = 4;
   localparam int unsigned CTRL_ACK_BIT     = 28;
   localparam int unsigned DED_MASK_LSB     = 0;

   localparam int unsigned RD_CPU_LSB = 0;
   localparam int unsigned RD_TMR_LSB = 4;
   localparam int unsigned RD_IPI_LSB = 8;

   localparam int unsigned FIELD_MAX_W = 4;

   typedef struct packed {
      logic dup_req;
      logic spur_clr;
      logic unsupported;
      logic zero_mask;
   } ipt_flags_t;

endpackage

// File: rtl/ipt_decode.sv
module ipt_decode
   import ipt_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned MAX_CPUS = 4,
   parameter int unsigned NUM_CPUS = 4
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [MAX_CPUS-1:0] ipi_set,
   output logic [MAX_CPUS-1:0] ipi_clr,
   output logic [MAX_CPUS-1:0] tmr_clr,
   output logic                unsupported,
   output logic                zero_mask
);
   localparam logic [MAX_CPUS-1:0] CFG_MASK = MAX_CPUS'((64'd1 << NUM_CPUS) - 64'd1);

   logic                is_ctrl, is_istat, is_tstat, is_ireq;
   logic [MAX_CPUS-1:0] f_req, f_iclr, f_tclr, f_ded;
   logic                ack;
   logic                unused_wdata;

   assign is_ctrl  = wr_en && (addr == ADDR_W'(REG_CTRL));
   assign is_istat = wr_en && (addr == ADDR_W'(REG_IPI_STAT));
   assign is_tstat = wr_en && (addr == ADDR_W'(REG_TMR_STAT));
   assign is_ireq  = wr_en && (addr == ADDR_W'(REG_IPI_REQ));

   assign f_req  = wdata[CTRL_IPI_REQ_LSB +: MAX_CPUS];
   assign f_iclr = wdata[CTRL_IPI_CLR_LSB +: MAX_CPUS];
   assign f_tclr = wdata[CTRL_TMR_CLR_LSB +: MAX_CPUS];
   assign f_ded  = wdata[DED_MASK_LSB +: MAX_CPUS];
   assign ack    = wdata[CTRL_ACK_BIT];

   assign unused_wdata = ^wdata;

   always_comb begin
      ipi_set = '0;
      ipi_clr = '0;
      tmr_clr = '0;
      if (is_ctrl) begin
         ipi_set = f_req;
         ipi_clr = f_iclr;
         tmr_clr = f_tclr;
      end else if (is_istat) begin
         ipi_clr = f_ded;
      end else if (is_tstat) begin
         tmr_clr = f_ded;
      end else if (is_ireq) begin
         ipi_set = f_ded;
      end
      ipi_set &= CFG_MASK;
      ipi_clr &= CFG_MASK;
      tmr_clr &= CFG_MASK;
   end

   assign unsupported = is_ctrl && (f_req == '0) && (f_iclr == '0) &&
                        (f_tclr == '0) && !ack;
   assign zero_mask   = (is_istat || is_tstat || is_ireq) && (f_ded == '0);

endmodule

// File: rtl/ipt_pending.sv
module ipt_pending #(
   parameter int unsigned WIDTH    = 4,
   parameter int unsigned ACTIVE   = 4,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      if (i < ACTIVE) begin : g_live
         logic nxt;
         if (SET_WINS) begin : g_set_first
            assign nxt = set[i] | (q[i] & ~clr[i]);
         end else begin : g_clr_first
            assign nxt = (set[i] | q[i]) & ~clr[i];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= nxt;
         end
      end else begin : g_dead
         logic unused_lane;
         assign unused_lane = set[i] ^ clr[i];
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/ipt_sticky.sv
module ipt_sticky #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (hit[i]) q[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/ipt_rdmux.sv
module ipt_rdmux
   import ipt_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned MAX_CPUS = 4,
   parameter int unsigned CPU_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [CPU_W-1:0]    cpu,
   input  logic [MAX_CPUS-1:0] ipi_q,
   input  logic [MAX_CPUS-1:0] tmr_q,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data
);
   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      if (addr == ADDR_W'(REG_CTRL)) begin
         word[RD_CPU_LSB +: CPU_W]    = cpu;
         word[RD_TMR_LSB +: MAX_CPUS] = tmr_q;
         word[RD_IPI_LSB +: MAX_CPUS] = ipi_q;
      end else if (addr == ADDR_W'(REG_IPI_STAT)) begin
         word[DED_MASK_LSB +: MAX_CPUS] = ipi_q;
      end else if (addr == ADDR_W'(REG_TMR_STAT)) begin
         word[DED_MASK_LSB +: MAX_CPUS] = tmr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_en;
         rsp_data  <= rd_en ? word : '0;
      end
   end
endmodule

// File: rtl/ipt_unit.sv
module ipt_unit
   import ipt_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned MAX_CPUS = 4,
   parameter int unsigned NUM_CPUS = 3,
   parameter int unsigned CPU_W    = $clog2(MAX_CPUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [CPU_W-1:0]    req_cpu,
   input  logic                timer_tick,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   output logic [MAX_CPUS-1:0] ipi_irq,
   output logic [MAX_CPUS-1:0] tmr_irq,
   output logic                warn_dup_req,
   output logic                warn_spur_clr,
   output logic                err_unsupported,
   output logic                err_zero_mask
);
   localparam logic [MAX_CPUS-1:0] CFG_MASK = MAX_CPUS'((64'd1 << NUM_CPUS) - 64'd1);

   if (MAX_CPUS < 2 || MAX_CPUS > FIELD_MAX_W) begin : g_bad_max
      $error("ipt_unit: MAX_CPUS must lie in 2..4");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > MAX_CPUS) begin : g_bad_num
      $error("ipt_unit: NUM_CPUS must lie in 1..MAX_CPUS");
   end
   if (DATA_W <= CTRL_ACK_BIT) begin : g_bad_data
      $error("ipt_unit: DATA_W too narrow for the control fields");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ipt_unit: ADDR_W must be at least 2");
   end

   logic [MAX_CPUS-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
   logic                unsup_hit, zero_hit;
   ipt_flags_t          flag_hit, flag_q;

   ipt_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS), .NUM_CPUS(NUM_CPUS)
   ) u_decode (
      .wr_en      (req_valid && req_write),
      .addr       (req_addr),
      .wdata      (req_wdata),
      .ipi_set    (ipi_set),
      .ipi_clr    (ipi_clr),
      .tmr_clr    (tmr_clr),
      .unsupported(unsup_hit),
      .zero_mask  (zero_hit)
   );

   assign tmr_set = timer_tick ? CFG_MASK : '0;

   ipt_pending #(.WIDTH(MAX_CPUS), .ACTIVE(NUM_CPUS), .SET_WINS(1'b1)) u_ipi (
      .clk(clk), .rst_n(rst_n), .set(ipi_set), .clr(ipi_clr), .q(ipi_irq)
   );

   ipt_pending #(.WIDTH(MAX_CPUS), .ACTIVE(NUM_CPUS), .SET_WINS(1'b1)) u_tmr (
      .clk(clk), .rst_n(rst_n), .set(tmr_set), .clr(tmr_clr), .q(tmr_irq)
   );

   always_comb begin
      flag_hit             = '0;
      flag_hit.dup_req     = |(ipi_set & ipi_irq);
      flag_hit.spur_clr    = |(ipi_clr & ~ipi_irq);
      flag_hit.unsupported = unsup_hit;
      flag_hit.zero_mask   = zero_hit;
   end

   ipt_sticky #(.WIDTH($bits(ipt_flags_t))) u_flags (
      .clk(clk), .rst_n(rst_n), .hit(flag_hit), .q(flag_q)
   );

   assign warn_dup_req    = flag_q.dup_req;
   assign warn_spur_clr   = flag_q.spur_clr;
   assign err_unsupported = flag_q.unsupported;
   assign err_zero_mask   = flag_q.zero_mask;

   ipt_rdmux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS), .CPU_W(CPU_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (req_valid && !req_write),
      .addr     (req_addr),
      .cpu      (req_cpu),
      .ipi_q    (ipi_irq),
      .tmr_q    (tmr_irq),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data)
   );
endmodule

// File: rtl/ipt_unit_chk.sv
module ipt_unit_chk #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned MAX_CPUS = 4,
   parameter int unsigned NUM_CPUS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W-1:0]   req_wdata,
   input logic                timer_tick,
   input logic                rsp_valid,
   input logic [MAX_CPUS-1:0] ipi_irq,
   input logic [MAX_CPUS-1:0] tmr_irq,
   input logic                warn_dup_req,
   input logic                err_zero_mask
);
   localparam logic [MAX_CPUS-1:0] CFG = MAX_CPUS'((64'd1 << NUM_CPUS) - 64'd1);

   logic                ctrl_wr, ded_zero_wr;
   logic [MAX_CPUS-1:0] req_field;

   assign ctrl_wr     = req_valid && req_write && (req_addr == '0);
   assign ded_zero_wr = req_valid && req_write && (req_addr != '0) &&
                        (req_wdata[MAX_CPUS-1:0] == '0);
   assign req_field   = req_wdata[12 +: MAX_CPUS] & CFG;

   AST_UNCFG_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipi_irq | tmr_irq) & ~CFG) == '0);                               // R5

   AST_TICK_RAISES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      timer_tick |=> ((tmr_irq & CFG) == CFG));                          // R4

   AST_CTRL_REQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && req_field != '0) |=> ((ipi_irq & $past(req_field)) == $past(req_field))); // R2

   AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);                          // R6

   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);                        // R6

   AST_ZERO_MASK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ded_zero_wr |=> err_zero_mask);                                    // R10

   AST_ZERO_MASK_KEEPS_IPI: assert property (@(posedge clk) disable iff (!rst_n)
      ded_zero_wr |=> $stable(ipi_irq));                                 // R10

   AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      warn_dup_req |=> warn_dup_req);                                    // R11
endmodule

bind ipt_unit ipt_unit_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS), .NUM_CPUS(NUM_CPUS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .timer_tick(timer_tick),
   .rsp_valid(rsp_valid), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
   .warn_dup_req(warn_dup_req), .err_zero_mask(err_zero_mask)
);

// File: tb/tb_ipt_unit.sv
`timescale 1ns/1ps
module tb_ipt_unit;
   localparam int DW = 64;
   localparam logic [3:0] CFG = 4'b0111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, timer_tick = 1'b0;
   logic [1:0]  req_addr = '0, req_cpu = '0;
   logic [DW-1:0] req_wdata = '0;
   logic        rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [3:0]  ipi_irq, tmr_irq;
   logic        warn_dup_req, warn_spur_clr, err_unsupported, err_zero_mask;

   int total = 0, bad = 0;
   bit done = 0;

   logic [3:0] m_ipi = '0, m_tmr = '0;
   logic       m_dup = 0, m_spur = 0, m_unsup = 0, m_zero = 0;

   always #4 clk = ~clk;

   ipt_unit #(.DATA_W(DW), .ADDR_W(2), .MAX_CPUS(4), .NUM_CPUS(3)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
      .timer_tick(timer_tick), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_dup_req(warn_dup_req),
      .warn_spur_clr(warn_spur_clr), .err_unsupported(err_unsupported),
      .err_zero_mask(err_zero_mask)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag);
      chk({tag, " ipi_irq"}, 64'(ipi_irq), 64'(m_ipi));
      chk({tag, " tmr_irq"}, 64'(tmr_irq), 64'(m_tmr));
      chk({tag, " flags R11"}, 64'({warn_dup_req, warn_spur_clr, err_unsupported, err_zero_mask}),
          64'({m_dup, m_spur, m_unsup, m_zero}));
   endtask

   function automatic logic [63:0] exp_read(logic [1:0] a, logic [1:0] cpu);
      case (a)
         2'd0:    return 64'({m_ipi, m_tmr, 2'b00, cpu});
         2'd1:    return 64'(m_ipi);
         2'd2:    return 64'(m_tmr);
         default: return 64'd0;
      endcase
   endfunction

   task automatic model_write(logic [1:0] a, logic [63:0] d, logic tick);
      logic [3:0] s, c, t, m;
      s = '0; c = '0; t = '0; m = d[3:0];
      if (a == 2'd0) begin
         s = d[15:12]; c = d[11:8]; t = d[7:4];
         if (d[15:4] == '0 && !d[28]) m_unsup = 1;
      end else begin
         if (m == '0) m_zero = 1;
         if (a == 2'd1) c = m;
         if (a == 2'd2) t = m;
         if (a == 2'd3) s = m;
      end
      s &= CFG; c &= CFG; t &= CFG;
      if ((s & m_ipi) != '0)  m_dup = 1;
      if ((c & ~m_ipi) != '0) m_spur = 1;
      m_ipi = s | (m_ipi & ~c);
      m_tmr = (tick ? CFG : 4'b0) | (m_tmr & ~t);
   endtask

   task automatic do_write(string tag, logic [1:0] a, logic [63:0] d, logic tick);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; timer_tick = tick;
      model_write(a, d, tick);
      @(negedge clk);
      req_valid = 0; req_write = 0; timer_tick = 0;
      chk_state(tag);
      chk({tag, " no rsp"}, 64'(rsp_valid), 64'd0);
   endtask

   task automatic do_tick(string tag);
      @(negedge clk);
      timer_tick = 1;
      m_tmr = CFG;
      @(negedge clk);
      timer_tick = 0;
      chk_state(tag);
   endtask

   task automatic do_read(string tag, logic [1:0] a, logic [1:0] cpu);
      logic [63:0] e;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_cpu = cpu;
      e = exp_read(a, cpu);
      @(negedge clk);
      req_valid = 0;
      chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " rsp_data"}, rsp_data, e);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk_state("R1 reset");
      chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);

      do_write("R2 request cpu0,cpu2", 2'd0, 64'h5000, 0);
      do_read("R6 ctrl read cpu2", 2'd0, 2'd2);
      do_write("R5 request cpu3 ignored", 2'd0, 64'h8000, 0);
      do_tick("R4 tick all cfg");
      do_write("R3 clear ipi cpu0", 2'd0, 64'h0100, 0);
      do_write("R3 req beats clear cpu0, R8 spur", 2'd0, 64'h1100, 0);
      do_write("R8 dup request cpu2", 2'd0, 64'h4000, 0);
      do_write("R4 tick beats timer clear", 2'd0, 64'h0030, 1);
      do_write("R3 timer clear cpu0,cpu1", 2'd0, 64'h0030, 0);
      do_read("R6 ctrl read cpu1", 2'd0, 2'd1);
      do_write("R9 ack bit alone", 2'd0, 64'h1000_0000, 0);
      do_write("R9 empty ctrl write", 2'd0, 64'h0, 0);
      do_read("R7 read ipi stat", 2'd1, 2'd0);
      do_write("R7 ipi stat clear cpu0", 2'd1, 64'h1, 0);
      do_write("R7 ipi req cpu1", 2'd3, 64'h2, 0);
      do_read("R7 read tmr stat", 2'd2, 2'd3);
      do_write("R7 tmr stat clear cpu2", 2'd2, 64'h4, 0);
      do_read("R7 read req reg", 2'd3, 2'd0);
      do_write("R10 zero mask on req reg", 2'd3, 64'h10, 0);

      void'($urandom(32'd2024));
      for (int i = 0; i < 500; i++) begin
         int op;
         logic [63:0] d;
         op = int'($urandom_range(0, 5));
         d = 64'($urandom) & 64'h0000_FFF0;
         if ($urandom_range(0, 7) == 0) d[28] = 1'b1;
         case (op)
            0, 1: do_write("R3 rand ctrl", 2'd0, d, 1'($urandom_range(0, 1)));
            2:    do_write("R7 rand ded", 2'($urandom_range(1, 3)),
                           64'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
            3:    do_tick("R4 rand tick");
            default: do_read("R6 rand read", 2'($urandom_range(0, 3)),
                             2'($urandom_range(0, 3)));
         endcase
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule